// File: doc/BRIEF.md
# Keyed Program-Memory Write Gate

This block sits between a register bus and the write port of a program memory and stops writes that software did not deliberately unlock. Software must write a fixed unlock byte into a write-only key register just before every program-memory write. A correct key arms a single-use permission. The next memory write request passes through and uses up that permission. A request that arrives without a fresh permission is held back, and a sticky failure flag records it.

Writing any other byte to the key register drops a pending permission. Reading the key register returns all ones, so the key cannot be read back. The failure flag stays set until a dedicated clear strobe removes it. The memory array is not part of this block. Only the allow signal and the failure flag leave it.

Top module: `key_write_gate`

## Requirements
- R1: A key-register write (keyWrEn high) whose data is 0xA3 arms the gate at that clock edge, so a memWrReq in the next cycle sees memWrAllow high.
- R2: memWrAllow is high in exactly the cycles where memWrReq is high and the gate is armed. It follows memWrReq in the same cycle with no register in the path.
- R3: Every memWrReq cycle, allowed or blocked, disarms the gate at its clock edge, so one key admits one write only.
- R4: A key-register write with any data other than 0xA3 disarms the gate.
- R5: A memWrReq while the gate is not armed sets failFlag at that edge. failFlag then stays high until it is cleared.
- R6: A failClr pulse clears failFlag at that edge. If a blocked request falls in the same cycle, failFlag is set instead.
- R7: keyRdData reads 0xFF while keyRdEn is high and 0x00 otherwise. Reads never change the armed state.
- R8: After reset the gate is disarmed and failFlag is low.
- R9: When a key write and memWrReq share a cycle, the request is judged on the state from before that cycle. The key data alone then decides the armed state that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| keyWrEn | input | 1 | Write strobe for the key register |
| keyWrData | input | 8 | Write data for the key register |
| keyRdEn | input | 1 | Read strobe for the key register |
| keyRdData | output | 8 | Read data of the key register |
| memWrReq | input | 1 | Program-memory write request |
| memWrAllow | output | 1 | Request is let through to the memory |
| failClr | input | 1 | Clears the failure flag |
| failFlag | output | 1 | Sticky flag for a blocked write |

## Verification
All 256 key byte values are swept. Each is written and then followed by one memory write. This shows that only 0xA3 arms the gate, and that every other value leaves the request blocked and raises the flag. Directed patterns follow:
- two writes after one key, which separates a single-use permission from a level enable;
- a valid key overwritten by a wrong one;
- a key write and a request in the same cycle, which separates old-state from new-state judging;
- a clear colliding with a blocked write;
- a read between key and write;
- a reset between key and write.

// File: rtl/key_gate_pkg.sv
package key_gate_pkg;
  localparam int unsigned DATA_W = 8;

  typedef struct packed {
    logic armSet;
    logic armClr;
    logic failSet;
    logic failClr;
  } gateStrobes_t;
endpackage

// File: rtl/key_gate_ctrl.sv
module key_gate_ctrl
  import key_gate_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter logic [DW-1:0] KEY_VAL = 8'hA3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          keyWrEn,
  input  logic [DW-1:0] keyWrData,
  input  logic          memWrReq,
  input  logic          failClr,
  input  logic          armed,
  output gateStrobes_t  strobes
);
  logic keyHit;

  always_comb begin
    keyHit          = keyWrEn && (keyWrData == KEY_VAL);
    strobes.armSet  = keyHit;
    strobes.armClr  = (keyWrEn && !keyHit) || memWrReq;
    strobes.failSet = memWrReq && !armed;
    strobes.failClr = failClr;
  end

  // R1
  key_arms_chk: assert property (@(posedge clk) disable iff (!rstN)
    keyHit |-> strobes.armSet && !(strobes.armClr && !memWrReq));

  // R5
  blocked_sets_fail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWrReq && !armed) |-> strobes.failSet);
endmodule

// File: rtl/key_gate_dp.sv
module key_gate_dp
  import key_gate_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  gateStrobes_t strobes,
  input  logic         memWrReq,
  input  logic         keyRdEn,
  output logic         armed,
  output logic         memWrAllow,
  output logic         failFlag,
  output logic [DW-1:0] keyRdData
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed    <= 1'b0;
      failFlag <= 1'b0;
    end else begin
      if (strobes.armSet)      armed <= 1'b1;
      else if (strobes.armClr) armed <= 1'b0;
      if (strobes.failSet)      failFlag <= 1'b1;
      else if (strobes.failClr) failFlag <= 1'b0;
    end
  end

  assign memWrAllow = memWrReq && armed;
  assign keyRdData  = keyRdEn ? {DW{1'b1}} : {DW{1'b0}};

  // R3
  single_use_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWrReq && !strobes.armSet) |=> !armed);

  // R5
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (failFlag && !strobes.failClr) |=> failFlag);

  // R6
  fail_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.failClr && !strobes.failSet) |=> !failFlag);
endmodule

// File: rtl/key_write_gate.sv
module key_write_gate
  import key_gate_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter logic [DW-1:0] KEY_VAL = 8'hA3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          keyWrEn,
  input  logic [DW-1:0] keyWrData,
  input  logic          keyRdEn,
  output logic [DW-1:0] keyRdData,
  input  logic          memWrReq,
  output logic          memWrAllow,
  input  logic          failClr,
  output logic          failFlag
);
  gateStrobes_t strobes;
  logic armed;

  key_gate_ctrl #(.DW(DW), .KEY_VAL(KEY_VAL)) uCtrl (
    .clk(clk), .rstN(rstN), .keyWrEn(keyWrEn), .keyWrData(keyWrData),
    .memWrReq(memWrReq), .failClr(failClr), .armed(armed), .strobes(strobes)
  );

  key_gate_dp #(.DW(DW)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .memWrReq(memWrReq),
    .keyRdEn(keyRdEn), .armed(armed), .memWrAllow(memWrAllow),
    .failFlag(failFlag), .keyRdData(keyRdData)
  );

  // R4
  wrong_key_disarms_chk: assert property (@(posedge clk) disable iff (!rstN)
    (keyWrEn && keyWrData != KEY_VAL) |=> !memWrAllow);

  // R2
  allow_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrAllow |-> memWrReq);
endmodule

// File: tb/tb_key_write_gate.sv
module tb_key_write_gate;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic keyWrEn = 1'b0;
  logic [7:0] keyWrData = 8'h00;
  logic keyRdEn = 1'b0;
  logic [7:0] keyRdData;
  logic memWrReq = 1'b0;
  logic memWrAllow;
  logic failClr = 1'b0;
  logic failFlag;
  int checks = 0;
  int failures = 0;
  logic allowSeen;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  key_write_gate dut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic keyWrite(input logic [7:0] v);
    keyWrEn = 1'b1;
    keyWrData = v;
    tick();
    keyWrEn = 1'b0;
  endtask

  task automatic memWrite(output logic allowed);
    memWrReq = 1'b1;
    #1 allowed = memWrAllow;
    tick();
    memWrReq = 1'b0;
  endtask

  task automatic clearFail();
    failClr = 1'b1;
    tick();
    failClr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R8 reset state
    check("R8 fail", {7'd0, failFlag}, 8'h00);
    memWrReq = 1'b1;
    #1 check("R8 armed", {7'd0, memWrAllow}, 8'h00);
    memWrReq = 1'b0;
    #1 check("R2 no req", {7'd0, memWrAllow}, 8'h00);
    tick();
    // R7 read data
    keyRdEn = 1'b1;
    #1 check("R7 rd", keyRdData, 8'hFF);
    keyRdEn = 1'b0;
    #1 check("R7 idle", keyRdData, 8'h00);

    // R1 R4 R5 sweep over all key values
    for (int v = 0; v < 256; v++) begin
      clearFail();
      check("R6 clr", {7'd0, failFlag}, 8'h00);
      keyWrite(v[7:0]);
      memWrite(allowSeen);
      check("R1 sweep allow", {7'd0, allowSeen}, {7'd0, v == 8'hA3});
      check("R5 sweep fail", {7'd0, failFlag}, {7'd0, v != 8'hA3});
    end

    // R3 single use
    clearFail();
    keyWrite(8'hA3);
    memWrite(allowSeen);
    check("R3 first", {7'd0, allowSeen}, 8'h01);
    memWrite(allowSeen);
    check("R3 second", {7'd0, allowSeen}, 8'h00);
    check("R5 second fail", {7'd0, failFlag}, 8'h01);

    // R5 sticky across an allowed write
    keyWrite(8'hA3);
    memWrite(allowSeen);
    check("R5 allowed", {7'd0, allowSeen}, 8'h01);
    check("R5 sticky", {7'd0, failFlag}, 8'h01);
    tick();
    check("R5 still", {7'd0, failFlag}, 8'h01);

    // R4 valid key overwritten by a wrong one
    clearFail();
    keyWrite(8'hA3);
    keyWrite(8'h5C);
    memWrite(allowSeen);
    check("R4 overwrite", {7'd0, allowSeen}, 8'h00);

    // R6 clear collides with blocked write: set wins
    failClr = 1'b1;
    memWrReq = 1'b1;
    tick();
    failClr = 1'b0;
    memWrReq = 1'b0;
    check("R6 collide", {7'd0, failFlag}, 8'h01);
    clearFail();

    // R7 read between key and write leaves armed
    keyWrite(8'hA3);
    keyRdEn = 1'b1;
    tick();
    keyRdEn = 1'b0;
    memWrite(allowSeen);
    check("R7 read no effect", {7'd0, allowSeen}, 8'h01);

    // R9 key write and request in the same cycle
    clearFail();
    keyWrEn = 1'b1;
    keyWrData = 8'hA3;
    memWrReq = 1'b1;
    #1 check("R9 old state", {7'd0, memWrAllow}, 8'h00);
    tick();
    keyWrEn = 1'b0;
    memWrReq = 1'b0;
    check("R9 fail", {7'd0, failFlag}, 8'h01);
    memWrite(allowSeen);
    check("R9 armed after", {7'd0, allowSeen}, 8'h01);

    // R9 armed, request plus wrong key in same cycle
    keyWrite(8'hA3);
    keyWrEn = 1'b1;
    keyWrData = 8'h00;
    memWrReq = 1'b1;
    #1 check("R9 old armed", {7'd0, memWrAllow}, 8'h01);
    tick();
    keyWrEn = 1'b0;
    memWrReq = 1'b0;
    memWrite(allowSeen);
    check("R9 disarmed", {7'd0, allowSeen}, 8'h00);

    // R8 reset clears armed and fail
    keyWrite(8'hA3);
    rstN = 1'b0;
    tick();
    rstN = 1'b1;
    check("R8 fail rst", {7'd0, failFlag}, 8'h00);
    memWrite(allowSeen);
    check("R8 armed rst", {7'd0, allowSeen}, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule